// File: doc/BRIEF.md
# Barrel Multithreaded Processor Core

This block is a small processor core that runs several hardware threads by interleaving them at the finest grain. On every clock it fetches one instruction, and each fetch belongs to the next thread in a fixed rotation. Every thread owns its program counter and a bank of four general registers, and all of them stay on chip. Changing threads therefore costs nothing: no state is saved and none is restored.

The pipeline is exactly as deep as the number of threads, `N`. Any instructions in flight at the same time come from different threads. A result or a new program counter is committed before its thread fetches again. The datapath has no hazard detection, no stall path and no forwarding network. Each thread gets one issue slot every `N` clocks whatever the others do, including a thread that spins in an endless loop or has halted.

The core uses one instruction memory port and one data memory port, and both are shared by all threads. Both memories are synchronous, with read data returned one clock after the address. A start-vector input gives each thread its program counter at reset, and a debug bus shows the current program counter of every thread.

Top module: `barrel_core`

## Requirements
- R1: After reset is released, `issue_tid` reads 0 in the first cycle and then advances by one each clock, wrapping from N-1 to 0. Exactly one thread is fetched per cycle, so each thread fetches once in every window of N cycles.
- R2: While reset is held, each thread's program counter, as shown on its slice of `pc_dbg` (thread i at bits i*PC_W upward), loads that thread's slice of `start_vec`. No store reaches the data port while reset is held.
- R3: In every cycle, `imem_addr` equals the program counter of the thread named by `issue_tid`.
- R4: Instruction word layout: bits 15:12 hold the opcode, 11:10 rd, 9:8 rs and 7:0 an unsigned immediate. The opcodes are 1 LDI (rd=imm), 2 ADD (rd=rd+rs), 3 SUB (rd=rd-rs), 4 ADDI (rd=rd+imm), 5 LD (rd=mem[rs]) and 6 ST (mem[rs]=rd). Arithmetic wraps at DATA_W bits. Opcode 0 and any opcode not listed here do nothing.
- R5: Opcode 7 BNZ sets the PC to imm when rd is nonzero. Opcode 8 JMP always sets the PC to imm. Only the executing thread's PC changes, and that thread's very next fetch uses the new PC, with no flush and no delay slot.
- R6: A store drives `dmem_we`, `dmem_addr` (= rs) and `dmem_wdata` (= rd) two cycles after its fetch cycle. A load presents its address in that same cycle and takes `dmem_rdata` in the following cycle.
- R7: A register written by one instruction holds the new value for the same thread's next instruction, so dependent instructions back to back give correct results without any stall.
- R8: Opcode 15 HALT holds its thread's PC on the HALT word. The thread keeps its slot in the rotation and writes neither registers nor memory.
- R9: A thread looping forever does not change the results or the issue timing of any other thread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_vec | input | N*PC_W | Reset PC for each thread, thread i in bits i*PC_W upward |
| imem_addr | output | PC_W | Fetch address of the thread issuing this cycle |
| imem_rdata | input | 16 | Instruction word, one cycle after the address |
| dmem_addr | output | DATA_W | Data memory address for a load or store |
| dmem_wdata | output | DATA_W | Store data |
| dmem_we | output | 1 | Store strobe |
| dmem_rdata | input | DATA_W | Load data, one cycle after the address |
| issue_tid | output | $clog2(N) | Thread fetched this cycle |
| pc_dbg | output | N*PC_W | Current PC of every thread |

## Verification
The fetch address and `issue_tid` belong to the current cycle, so the bench compares them with its own rotation counter in that same cycle. A store is due on the data port two cycles after its fetch slot. When `dmem_we` is high, the bench takes the thread that fetched two slots earlier and checks the address and value that this thread's program must produce. Register and PC commits land at the end of the Nth cycle after the fetch. Final register contents are therefore read through stores and final PCs through `pc_dbg`, both after the programs have settled. All sampling happens on the falling edge, away from the edge that moves the pipeline.

// File: rtl/barrel_pkg.sv
package barrel_pkg;

    localparam int INSTR_W = 16;
    localparam int NREG    = 4;
    localparam int RIDX_W  = 2;
    localparam int IMM_W   = 8;

    typedef enum logic [3:0] {
        OP_NOP  = 4'd0,
        OP_LDI  = 4'd1,
        OP_ADD  = 4'd2,
        OP_SUB  = 4'd3,
        OP_ADDI = 4'd4,
        OP_LD   = 4'd5,
        OP_ST   = 4'd6,
        OP_BNZ  = 4'd7,
        OP_JMP  = 4'd8,
        OP_HALT = 4'd15
    } op_e;

    typedef struct packed {
        logic [3:0]        opc;
        logic [RIDX_W-1:0] rd;
        logic [RIDX_W-1:0] rs;
        logic [IMM_W-1:0]  imm;
    } instr_t;

    typedef struct packed {
        logic reg_we;
        logic is_load;
        logic is_store;
        logic br_cond;
        logic br_always;
        logic halt;
    } ctl_t;

    function automatic op_e decode_op(input logic [3:0] raw);
        case (raw)
            4'd1:    return OP_LDI;
            4'd2:    return OP_ADD;
            4'd3:    return OP_SUB;
            4'd4:    return OP_ADDI;
            4'd5:    return OP_LD;
            4'd6:    return OP_ST;
            4'd7:    return OP_BNZ;
            4'd8:    return OP_JMP;
            4'd15:   return OP_HALT;
            default: return OP_NOP;
        endcase
    endfunction

    function automatic ctl_t decode_ctl(input op_e op);
        ctl_t c;
        c = '0;
        case (op)
            OP_LDI, OP_ADD, OP_SUB, OP_ADDI: c.reg_we = 1'b1;
            OP_LD:   begin c.reg_we = 1'b1; c.is_load = 1'b1; end
            OP_ST:   c.is_store  = 1'b1;
            OP_BNZ:  c.br_cond   = 1'b1;
            OP_JMP:  c.br_always = 1'b1;
            OP_HALT: c.halt      = 1'b1;
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/barrel_thread_sel.sv
module barrel_thread_sel #(
    parameter int N = 8,
    localparam int TID_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    output logic [TID_W-1:0] tid
);

    logic [TID_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (cnt_q == TID_W'(N - 1))
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign tid = cnt_q;

endmodule

// File: rtl/barrel_pc_bank.sv
module barrel_pc_bank #(
    parameter int N    = 8,
    parameter int PC_W = 8,
    localparam int TID_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N*PC_W-1:0] start_vec,
    input  logic              wr_en,
    input  logic [TID_W-1:0]  wr_tid,
    input  logic [PC_W-1:0]   wr_pc,
    output logic [N*PC_W-1:0] pc_flat
);

    logic [PC_W-1:0] pc_q [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++)
                pc_q[i] <= start_vec[i*PC_W +: PC_W];
        end else if (wr_en) begin
            pc_q[wr_tid] <= wr_pc;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_flat
        assign pc_flat[i*PC_W +: PC_W] = pc_q[i];
    end

endmodule

// File: rtl/barrel_regfile.sv
module barrel_regfile
    import barrel_pkg::*;
#(
    parameter int N      = 8,
    parameter int DATA_W = 16,
    localparam int TID_W = (N > 1) ? $clog2(N) : 1,
    localparam int DEPTH = N * NREG,
    localparam int ADR_W = TID_W + RIDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TID_W-1:0]  rd_tid,
    input  logic [RIDX_W-1:0] rd_a_idx,
    input  logic [RIDX_W-1:0] rd_b_idx,
    output logic [DATA_W-1:0] rd_a,
    output logic [DATA_W-1:0] rd_b,
    input  logic              wr_en,
    input  logic [TID_W-1:0]  wr_tid,
    input  logic [RIDX_W-1:0] wr_idx,
    input  logic [DATA_W-1:0] wr_data
);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [ADR_W-1:0]  a_adr, b_adr, w_adr;

    assign a_adr = {rd_tid, rd_a_idx};
    assign b_adr = {rd_tid, rd_b_idx};
    assign w_adr = {wr_tid, wr_idx};

    assign rd_a = mem_q[a_adr];
    assign rd_b = mem_q[b_adr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < DEPTH; k++)
                mem_q[k] <= '0;
        end else if (wr_en) begin
            mem_q[w_adr] <= wr_data;
        end
    end

endmodule

// File: rtl/barrel_exec.sv
module barrel_exec
    import barrel_pkg::*;
#(
    parameter int PC_W   = 8,
    parameter int DATA_W = 16
) (
    input  op_e               op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [IMM_W-1:0]  imm,
    input  logic [PC_W-1:0]   pc,
    output logic [DATA_W-1:0] result,
    output logic [PC_W-1:0]   npc,
    output ctl_t              ctl
);

    logic [DATA_W-1:0] imm_x;
    logic [PC_W-1:0]   target;

    assign ctl    = decode_ctl(op);
    assign imm_x  = DATA_W'(imm);
    assign target = PC_W'(imm);

    always_comb begin
        case (op)
            OP_LDI:  result = imm_x;
            OP_ADD:  result = a + b;
            OP_SUB:  result = a - b;
            OP_ADDI: result = a + imm_x;
            default: result = '0;
        endcase
    end

    always_comb begin
        if (ctl.halt)
            npc = pc;
        else if (ctl.br_always || (ctl.br_cond && (a != '0)))
            npc = target;
        else
            npc = pc + 1'b1;
    end

endmodule

// File: rtl/barrel_core.sv
module barrel_core
    import barrel_pkg::*;
#(
    parameter int N      = 8,
    parameter int PC_W   = 8,
    parameter int DATA_W = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [N*PC_W-1:0]      start_vec,
    output logic [PC_W-1:0]        imem_addr,
    input  logic [INSTR_W-1:0]     imem_rdata,
    output logic [DATA_W-1:0]      dmem_addr,
    output logic [DATA_W-1:0]      dmem_wdata,
    output logic                   dmem_we,
    input  logic [DATA_W-1:0]      dmem_rdata,
    output logic [$clog2(N)-1:0]   issue_tid,
    output logic [N*PC_W-1:0]      pc_dbg
);

    localparam int TID_W = (N > 1) ? $clog2(N) : 1;
    localparam int NPAD  = N - 4;

    typedef struct packed {
        logic             v;
        logic [TID_W-1:0] tid;
        logic [PC_W-1:0]  pc;
    } fet_t;

    typedef struct packed {
        logic              v;
        logic [TID_W-1:0]  tid;
        logic [PC_W-1:0]   pc;
        op_e               op;
        logic [RIDX_W-1:0] rd;
        logic [IMM_W-1:0]  imm;
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
    } dec_t;

    typedef struct packed {
        logic              v;
        logic [TID_W-1:0]  tid;
        logic [RIDX_W-1:0] rd;
        logic              we;
        logic              is_load;
        logic [DATA_W-1:0] data;
        logic [PC_W-1:0]   npc;
    } wb_t;

    // fetch stage
    logic [TID_W-1:0]  sel_tid;
    logic [PC_W-1:0]   sel_pc;
    logic [N*PC_W-1:0] pc_flat;

    barrel_thread_sel #(.N(N)) u_sel (
        .clk (clk),
        .rst (rst),
        .tid (sel_tid)
    );

    assign sel_pc    = pc_flat[sel_tid*PC_W +: PC_W];
    assign imem_addr = sel_pc;
    assign issue_tid = sel_tid;
    assign pc_dbg    = pc_flat;

    fet_t p1_q;
    always_ff @(posedge clk) begin
        if (rst)
            p1_q <= '0;
        else
            p1_q <= '{v: 1'b1, tid: sel_tid, pc: sel_pc};
    end

    // decode and register read stage
    instr_t            ins;
    op_e               dec_op;
    logic [DATA_W-1:0] rf_a, rf_b;

    assign ins    = instr_t'(imem_rdata);
    assign dec_op = decode_op(ins.opc);

    logic              commit_v;
    logic [TID_W-1:0]  commit_tid;
    wb_t               commit;

    barrel_regfile #(.N(N), .DATA_W(DATA_W)) u_rf (
        .clk      (clk),
        .rst      (rst),
        .rd_tid   (p1_q.tid),
        .rd_a_idx (ins.rd),
        .rd_b_idx (ins.rs),
        .rd_a     (rf_a),
        .rd_b     (rf_b),
        .wr_en    (commit.v && commit.we),
        .wr_tid   (commit.tid),
        .wr_idx   (commit.rd),
        .wr_data  (commit.data)
    );

    dec_t p2_q;
    always_ff @(posedge clk) begin
        if (rst)
            p2_q <= '0;
        else
            p2_q <= '{v: p1_q.v, tid: p1_q.tid, pc: p1_q.pc, op: dec_op,
                      rd: ins.rd, imm: ins.imm, a: rf_a, b: rf_b};
    end

    // execute stage
    logic [DATA_W-1:0] ex_res;
    logic [PC_W-1:0]   ex_npc;
    ctl_t              ex_ctl;

    barrel_exec #(.PC_W(PC_W), .DATA_W(DATA_W)) u_exec (
        .op     (p2_q.op),
        .a      (p2_q.a),
        .b      (p2_q.b),
        .imm    (p2_q.imm),
        .pc     (p2_q.pc),
        .result (ex_res),
        .npc    (ex_npc),
        .ctl    (ex_ctl)
    );

    assign dmem_addr  = p2_q.b;
    assign dmem_wdata = p2_q.a;
    assign dmem_we    = p2_q.v && ex_ctl.is_store;

    wb_t p3_q;
    always_ff @(posedge clk) begin
        if (rst)
            p3_q <= '0;
        else
            p3_q <= '{v: p2_q.v, tid: p2_q.tid, rd: p2_q.rd, we: ex_ctl.reg_we,
                      is_load: ex_ctl.is_load, data: ex_res, npc: ex_npc};
    end

    // load merge, then padding up to the commit stage
    wb_t wb_res;
    always_comb begin
        wb_res = p3_q;
        if (p3_q.is_load)
            wb_res.data = dmem_rdata;
    end

    for (genvar k = 0; k < NPAD; k++) begin : g_pad
        wb_t q;
        if (k == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) q <= '0;
                else     q <= wb_res;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) q <= '0;
                else     q <= g_pad[k-1].q;
            end
        end
    end

    if (NPAD == 0) begin : g_commit_direct
        assign commit = wb_res;
    end else begin : g_commit_pad
        assign commit = g_pad[NPAD-1].q;
    end

    assign commit_v   = commit.v;
    assign commit_tid = commit.tid;

    barrel_pc_bank #(.N(N), .PC_W(PC_W)) u_pc (
        .clk       (clk),
        .rst       (rst),
        .start_vec (start_vec),
        .wr_en     (commit_v),
        .wr_tid    (commit_tid),
        .wr_pc     (commit.npc),
        .pc_flat   (pc_flat)
    );

endmodule

// File: rtl/barrel_core_chk.sv
module barrel_core_chk #(
    parameter int N    = 8,
    parameter int PC_W = 8,
    localparam int TID_W = (N > 1) ? $clog2(N) : 1
) (
    input logic              clk,
    input logic              rst,
    input logic [N*PC_W-1:0] start_vec,
    input logic [PC_W-1:0]   imem_addr,
    input logic [TID_W-1:0]  issue_tid,
    input logic [N*PC_W-1:0] pc_dbg,
    input logic              dmem_we,
    input logic              commit_v,
    input logic [TID_W-1:0]  commit_tid
);

    // R1: the rotation starts at thread 0 once reset is released
    assert_rot_start_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> issue_tid == '0);

    // R1: the rotation advances by one each cycle and wraps
    assert_rot_step_R1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> issue_tid == (($past(issue_tid) == TID_W'(N - 1)) ? '0
                                      : $past(issue_tid) + 1'b1));

    // R2: every PC holds its start vector on leaving reset
    assert_start_pc_R2: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> pc_dbg == $past(start_vec));

    // R2: no store while reset is held
    always @(posedge clk) begin
        if (rst)
            assert_no_store_in_reset_R2: assert (!dmem_we);
    end

    // R3: the fetch address is the issuing thread's PC
    assert_fetch_addr_R3: assert property (@(posedge clk) disable iff (rst)
        imem_addr == pc_dbg[issue_tid*PC_W +: PC_W]);

    // R5: a PC moves only when its own thread commits
    for (genvar i = 0; i < N; i++) begin : g_pc
        assert_pc_own_R5: assert property (@(posedge clk) disable iff (rst)
            (!commit_v || commit_tid != TID_W'(i)) |=> $stable(pc_dbg[i*PC_W +: PC_W]));
    end

endmodule

bind barrel_core barrel_core_chk #(.N(N), .PC_W(PC_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_vec  (start_vec),
    .imem_addr  (imem_addr),
    .issue_tid  (issue_tid),
    .pc_dbg     (pc_dbg),
    .dmem_we    (dmem_we),
    .commit_v   (commit_v),
    .commit_tid (commit_tid)
);

// File: tb/barrel_core_test.sv
module barrel_core_test;

    localparam int N      = 8;
    localparam int PC_W   = 8;
    localparam int DATA_W = 16;
    localparam int TID_W  = $clog2(N);
    localparam int SPIN   = 7;

    // per program: count, step, preload, expected store value; count 0 = spin forever
    localparam logic [63:0] TBL [N] = '{
        {16'd3,  16'd5,    16'd0,   16'd15},
        {16'd10, 16'd7,    16'd2,   16'd72},
        {16'd1,  16'd255,  16'd1,   16'd256},
        {16'd20, 16'd200,  16'd0,   16'd4000},
        {16'd5,  16'd0,    16'd9,   16'd9},
        {16'd4,  16'd200,  16'd100, 16'd900},
        {16'd12, 16'd250,  16'd5,   16'd3005},
        {16'd0,  16'd0,    16'h1234,16'h1234}
    };

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [N*PC_W-1:0]  start_vec;
    logic [PC_W-1:0]    imem_addr;
    logic [15:0]        imem_rdata;
    logic [DATA_W-1:0]  dmem_addr, dmem_wdata, dmem_rdata;
    logic               dmem_we;
    logic [TID_W-1:0]   issue_tid;
    logic [N*PC_W-1:0]  pc_dbg;

    logic [15:0] imem [256];
    logic [15:0] dmem [256];

    int n_chk  = 0;
    int n_fail = 0;
    int rot    = 0;

    always #5 clk = ~clk;

    barrel_core #(.N(N), .PC_W(PC_W), .DATA_W(DATA_W)) uut (
        .clk        (clk),
        .rst        (rst),
        .start_vec  (start_vec),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata),
        .issue_tid  (issue_tid),
        .pc_dbg     (pc_dbg)
    );

    always @(posedge clk) begin
        imem_rdata <= imem[imem_addr];
        dmem_rdata <= dmem[dmem_addr[7:0]];
        if (dmem_we)
            dmem[dmem_addr[7:0]] <= dmem_wdata;
    end

    function automatic logic [15:0] mk(input int op, input int rd, input int rs, input int imm);
        return {4'(op), 2'(rd), 2'(rs), 8'(imm)};
    endfunction

    task automatic check(input bit ok, input string msg);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s", msg);
        end
    endtask

    task automatic load_programs(input int r);
        for (int a = 0; a < 256; a++) imem[a] = 16'h0000;
        for (int j = 0; j < N; j++) begin
            int b;
            b = j * 16;
            if (TBL[j][63:48] == 16'd0) begin
                imem[b] = mk(8, 0, 0, b);
            end else begin
                imem[b+0]  = mk(1, 0, 0, TBL[j][63:48]);
                imem[b+1]  = mk(1, 1, 0, 0);
                imem[b+2]  = mk(1, 2, 0, TBL[j][47:32]);
                imem[b+3]  = mk(1, 3, 0, 1);
                imem[b+4]  = mk(2, 1, 2, 0);
                imem[b+5]  = mk(3, 0, 3, 0);
                imem[b+6]  = mk(7, 0, 0, b + 4);
                imem[b+7]  = mk(1, 3, 0, 8'h40 + j);
                imem[b+8]  = mk(5, 2, 3, 0);
                imem[b+9]  = mk(2, 1, 2, 0);
                imem[b+10] = mk(6, 1, 3, 0);
                imem[b+11] = mk(15, 0, 0, 0);
            end
            dmem[8'h40 + j] <= TBL[j][31:16];
        end
        for (int i = 0; i < N; i++)
            start_vec[i*PC_W +: PC_W] = PC_W'(((i + r) % N) * 16);
    endtask

    task automatic run_cycles(input int n);
        int exp_tid;
        exp_tid = 0;
        for (int c = 0; c < n; c++) begin
            check(issue_tid == TID_W'(exp_tid),
                  $sformatf("R1 rotation act=%0d exp=%0d", issue_tid, exp_tid));
            check(imem_addr == pc_dbg[issue_tid*PC_W +: PC_W],
                  $sformatf("R3 fetch addr act=%0d exp=%0d", imem_addr,
                            pc_dbg[issue_tid*PC_W +: PC_W]));
            if (dmem_we) begin
                int thr, prog;
                thr  = (int'(issue_tid) + N - 2) % N;
                prog = (thr + rot) % N;
                // R6: store appears two slots after its fetch; R4/R7 value
                check(dmem_addr == DATA_W'(8'h40 + prog),
                      $sformatf("R6 store addr act=%0h exp=%0h", dmem_addr, 8'h40 + prog));
                check(dmem_wdata == TBL[prog][15:0],
                      $sformatf("R4 R7 store data act=%0d exp=%0d", dmem_wdata, TBL[prog][15:0]));
            end
            exp_tid = (exp_tid + 1) % N;
            @(negedge clk);
        end
    endtask

    task automatic phase(input int r);
        rot = r;
        rst = 1'b1;
        load_programs(r);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(pc_dbg == start_vec, $sformatf("R2 reset pc act=%0h exp=%0h", pc_dbg, start_vec));
        check(!dmem_we, $sformatf("R2 store in reset act=%0b exp=0", dmem_we));
        rst = 1'b0;
        run_cycles(1500);
        for (int i = 0; i < N; i++) begin
            int prog;
            logic [PC_W-1:0] exp_pc;
            prog = (i + r) % N;
            check(dmem[8'h40 + prog] == TBL[prog][15:0],
                  $sformatf("R4 R9 final mem[%0h] act=%0d exp=%0d", 8'h40 + prog,
                            dmem[8'h40 + prog], TBL[prog][15:0]));
            exp_pc = (prog == SPIN) ? PC_W'(prog * 16) : PC_W'(prog * 16 + 11);
            // R8 halted PC stays on HALT; R5 spinning PC stays on its jump
            check(pc_dbg[i*PC_W +: PC_W] == exp_pc,
                  $sformatf("R8 R5 final pc t%0d act=%0d exp=%0d", i,
                            pc_dbg[i*PC_W +: PC_W], exp_pc));
        end
    endtask

    initial begin
        phase(0);
        phase(3);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 10);
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail + 1);
        $finish;
    end

endmodule